// File: doc/BRIEF.md
# Upper Memory Shadow Routing Controller

This block is a chipset configuration unit that software reaches through a pair of I/O ports: one port selects a register number, the other reads or writes the selected byte in a 256-entry register file. Two of those registers control where accesses to the upper memory window (0xC0000 to 0xFFFFF) go. Each access goes either to internal shadow RAM or out to the external bus, and reads and writes are routed independently.

The window is split into eight 32 KB segments. A per-segment enable mask and a shared two-bit routing mode decide the outcome. Routing is decoded combinationally from the memory address. Two flag outputs report the BIOS shadow read and write settings to the rest of the chipset. When a CPU-variant input is high, certain register numbers read back as all ones so that they do not collide with configuration registers that belong to that processor.

Top module: `shadow_ctrl`

## Requirements
- R1: A write strobe with `io_addr0` low loads `io_wdata` into the index register on the next clock edge. After reset the index register is 0x00.
- R2: A write strobe with `io_addr0` high stores `io_wdata` into the register that the current index selects. The new value is visible from the next cycle. After reset all 256 registers hold 0xFF.
- R3: With `io_rd` high, `io_addr0` low returns the index and `io_addr0` high returns the selected register. With `io_rd` low, `io_rdata` is 0x00.
- R4: Segment c (c = 0..7) spans 0xC0000 + c*0x8000 up to 0xC0000 + c*0x8000 + 0x7FFF. When bit c of register 0x13 is 0, reads and writes to that segment both route external.
- R5: For an enabled segment, bits [1:0] of register 0x14 set the routing: 0 means both external, 1 means reads internal, 2 means writes internal, 3 means both internal.
- R6: Addresses below 0xC0000 or above 0xFFFFF always route external for reads and writes.
- R7: `bios_shadow_rd` equals bit 0 of register 0x14 and `bios_shadow_wr` equals bit 1. Both are 1 after reset.
- R8: With `cpu_alt` high, a data-port read at index 0x20 or at any index of 0xC0 or above returns 0xFF. The stored byte is kept, and it reads back when `cpu_alt` is low. Index-port reads are never masked.
- R9: `acc_int` equals `seg_wr_int` when `mem_wr` is 1 and `seg_rd_int` when `mem_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr0 | input | 1 | I/O port select: 0 = index port, 1 = data port |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| mem_addr | input | 24 | Memory access address |
| mem_wr | input | 1 | Access kind: 1 = write, 0 = read |
| cpu_alt | input | 1 | CPU-variant flag that enables register read masking |
| seg_rd_int | output | 1 | A read at `mem_addr` goes to internal RAM |
| seg_wr_int | output | 1 | A write at `mem_addr` goes to internal RAM |
| acc_int | output | 1 | The current access goes to internal RAM |
| bios_shadow_rd | output | 1 | BIOS shadow read flag |
| bios_shadow_wr | output | 1 | BIOS shadow write flag |

## Verification
The bench sets each routing mode on each segment in turn. It probes the first and last byte of the segment and the first byte of the next one. A decoder that takes the segment number from the wrong address bits, or that lets one segment's enable cover its neighbour, routes one of those three probes wrongly. Probes just outside both ends of the window catch an off-by-one window compare. Masked reads are tried at 0x1F, 0x20, 0xC0 and 0xFF with the variant flag both high and low. This exposes a mask that is missing, one that destroys the stored byte, one that has the wrong floor, and one that also hits the index port. Swapping the two mode bits shows up as reads and writes trading places in modes 1 and 2.

// File: rtl/shadow_ctrl_pkg.sv
package shadow_ctrl_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 8;
  localparam int NSEG     = 8;
  localparam int SEG_BITS = 15;

  localparam logic [IDX_W-1:0] REG_SEG_EN  = 8'h13;
  localparam logic [IDX_W-1:0] REG_ROUTE   = 8'h14;
  localparam logic [IDX_W-1:0] MASK_SINGLE = 8'h20;
  localparam logic [IDX_W-1:0] MASK_FLOOR  = 8'hC0;

  typedef enum logic [1:0] {
    RT_ALL_EXT = 2'd0,
    RT_RD_INT  = 2'd1,
    RT_WR_INT  = 2'd2,
    RT_ALL_INT = 2'd3
  } route_mode_e;
endpackage

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
  parameter int DW = 8,
  parameter int IW = 8,
  parameter logic [DW-1:0] RST_VAL = '1,
  parameter logic [IW-1:0] CTL_A = '0,
  parameter logic [IW-1:0] CTL_B = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ctl_a_q,
  output logic [1:0]    ctl_b_lo
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic          ce;
    logic [DW-1:0] d;
    always_comb begin
      ce = wr_en && (wr_idx == IW'(i));
      d  = ce ? wr_data : mem_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= RST_VAL;
      else if (ce) mem_q[i] <= d;
    end
  end

  logic [DW-1:0] ctl_b_full;
  always_comb begin
    rd_data    = mem_q[rd_idx];
    ctl_a_q    = mem_q[CTL_A];
    ctl_b_full = mem_q[CTL_B];
    ctl_b_lo   = ctl_b_full[1:0];
  end
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_ctrl_pkg::*;
#(
  parameter int AW = 24,
  parameter int NS = 8,
  parameter int SB = 15,
  parameter logic [AW-1:0] BASE = 24'h0C0000
) (
  input  logic [AW-1:0]  addr,
  input  logic           wr,
  input  logic [NS-1:0]  seg_en,
  input  route_mode_e    mode,
  output logic           rd_int,
  output logic           wr_int,
  output logic           acc_int
);
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;
  localparam logic [AW-1:0] SPAN = AW'(NS) << SB;

  logic [AW-1:0] offset;
  logic          in_win;
  logic [SW-1:0] seg;
  logic [NS-1:0] hit;

  always_comb begin
    offset = addr - BASE;
    in_win = (addr >= BASE) && (offset < SPAN);
    seg    = offset[SB +: SW];
  end

  for (genvar c = 0; c < NS; c++) begin : g_seg
    assign hit[c] = in_win && (seg == SW'(c)) && seg_en[c];
  end

  always_comb begin
    rd_int  = (|hit) && mode[0];
    wr_int  = (|hit) && mode[1];
    acc_int = wr ? wr_int : rd_int;
  end
endmodule

// File: rtl/shadow_rd_mux.sv
module shadow_rd_mux #(
  parameter int DW = 8,
  parameter int IW = 8,
  parameter logic [IW-1:0] MSK_ONE = 8'h20,
  parameter logic [IW-1:0] MSK_LO  = 8'hC0
) (
  input  logic          rd,
  input  logic          sel_data,
  input  logic          cpu_alt,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] reg_val,
  output logic [DW-1:0] rdata
);
  logic masked;
  always_comb begin
    masked = cpu_alt && ((idx == MSK_ONE) || (idx >= MSK_LO));
    if (!rd)          rdata = '0;
    else if (!sel_data) rdata = DW'(idx);
    else if (masked)  rdata = '1;
    else              rdata = reg_val;
  end
endmodule

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_ctrl_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_addr0,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [AW-1:0]     mem_addr,
  input  logic              mem_wr,
  input  logic              cpu_alt,
  output logic              seg_rd_int,
  output logic              seg_wr_int,
  output logic              acc_int,
  output logic              bios_shadow_rd,
  output logic              bios_shadow_wr
);
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_ce;
  logic              data_we;
  logic [DATA_W-1:0] reg_val;
  logic [DATA_W-1:0] seg_en_q;
  logic [1:0]        route_q;
  route_mode_e       mode;

  always_comb begin
    idx_ce  = io_wr && !io_addr0;
    idx_d   = idx_ce ? io_wdata : idx_q;
    data_we = io_wr && io_addr0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_ce) idx_q <= idx_d;
  end

  shadow_regfile #(
    .DW(DATA_W), .IW(IDX_W), .RST_VAL('1),
    .CTL_A(REG_SEG_EN), .CTL_B(REG_ROUTE)
  ) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(data_we), .wr_idx(idx_q), .wr_data(io_wdata),
    .rd_idx(idx_q), .rd_data(reg_val),
    .ctl_a_q(seg_en_q), .ctl_b_lo(route_q)
  );

  assign mode = route_mode_e'(route_q);
  assign bios_shadow_rd = route_q[0];
  assign bios_shadow_wr = route_q[1];

  shadow_seg_decode #(
    .AW(AW), .NS(NSEG), .SB(SEG_BITS), .BASE(AW'(24'h0C0000))
  ) u_dec (
    .addr(mem_addr), .wr(mem_wr), .seg_en(seg_en_q[NSEG-1:0]), .mode(mode),
    .rd_int(seg_rd_int), .wr_int(seg_wr_int), .acc_int(acc_int)
  );

  shadow_rd_mux #(
    .DW(DATA_W), .IW(IDX_W), .MSK_ONE(MASK_SINGLE), .MSK_LO(MASK_FLOOR)
  ) u_rmux (
    .rd(io_rd), .sel_data(io_addr0), .cpu_alt(cpu_alt),
    .idx(idx_q), .reg_val(reg_val), .rdata(io_rdata)
  );
endmodule

// File: rtl/shadow_ctrl_chk.sv
module shadow_ctrl_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_addr0,
  input logic          io_wr,
  input logic          io_rd,
  input logic [7:0]    io_wdata,
  input logic [7:0]    io_rdata,
  input logic [AW-1:0] mem_addr,
  input logic          mem_wr,
  input logic          cpu_alt,
  input logic          seg_rd_int,
  input logic          seg_wr_int,
  input logic          acc_int,
  input logic          bios_shadow_rd,
  input logic          bios_shadow_wr,
  input logic [7:0]    idx_q,
  input logic [7:0]    seg_en_q
);
  logic in_win;
  assign in_win = (mem_addr >= AW'(24'h0C0000)) && (mem_addr <= AW'(24'h0FFFFF));

  // R1
  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_addr0) |=> (idx_q == $past(io_wdata)));

  // R3
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));

  // R4
  p_seg_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !seg_en_q[mem_addr[17:15]]) |-> (!seg_rd_int && !seg_wr_int));

  // R6
  p_outside_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (!seg_rd_int && !seg_wr_int));

  // R7
  p_bios_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr0 && idx_q == 8'h14) |=>
      (bios_shadow_rd == $past(io_wdata[0]) && bios_shadow_wr == $past(io_wdata[1])));

  // R8
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr0 && cpu_alt && (idx_q == 8'h20 || idx_q >= 8'hC0)) |-> (io_rdata == 8'hFF));

  // R9
  p_acc_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_int == (mem_wr ? seg_wr_int : seg_rd_int));
endmodule

bind shadow_ctrl shadow_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr0(io_addr0), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr), .mem_wr(mem_wr),
  .cpu_alt(cpu_alt), .seg_rd_int(seg_rd_int), .seg_wr_int(seg_wr_int),
  .acc_int(acc_int), .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr),
  .idx_q(idx_q), .seg_en_q(seg_en_q)
);

// File: tb/tb_shadow_ctrl.sv
module tb_shadow_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_addr0, io_wr, io_rd, mem_wr, cpu_alt;
  logic [7:0]  io_wdata, io_rdata;
  logic [23:0] mem_addr;
  logic        seg_rd_int, seg_wr_int, acc_int, bios_shadow_rd, bios_shadow_wr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shadow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .io_addr0(io_addr0), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .cpu_alt(cpu_alt), .seg_rd_int(seg_rd_int), .seg_wr_int(seg_wr_int),
    .acc_int(acc_int), .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_put(logic a0, logic [7:0] d);
    @(negedge clk);
    io_addr0 = a0; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic reg_put(logic [7:0] idx, logic [7:0] v);
    io_put(1'b0, idx);
    io_put(1'b1, v);
  endtask

  task automatic io_get(logic a0, output logic [7:0] v);
    io_addr0 = a0; io_rd = 1'b1;
    #1 v = io_rdata;
    io_rd = 1'b0;
    #1;
  endtask

  task automatic reg_get(logic [7:0] idx, output logic [7:0] v);
    io_put(1'b0, idx);
    io_get(1'b1, v);
  endtask

  task automatic route_chk(string tag, logic [23:0] a, logic er, logic ew);
    mem_addr = a; mem_wr = 1'b0;
    #1;
    check({tag, " rd"}, 32'(seg_rd_int), 32'(er));
    check({tag, " wr"}, 32'(seg_wr_int), 32'(ew));
    check({tag, " R9 acc(read)"}, 32'(acc_int), 32'(er));
    mem_wr = 1'b1;
    #1;
    check({tag, " R9 acc(write)"}, 32'(acc_int), 32'(ew));
    mem_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    io_get(1'b0, v);
    check("R1 index after reset", 32'(v), 32'h00);
    io_get(1'b1, v);
    check("R2 reg 0x00 after reset", 32'(v), 32'hFF);
    reg_get(8'h55, v);
    check("R2 reg 0x55 after reset", 32'(v), 32'hFF);
    check("R7 bios rd after reset", 32'(bios_shadow_rd), 32'd1);
    check("R7 bios wr after reset", 32'(bios_shadow_wr), 32'd1);
    route_chk("R5 reset mode 3 at 0xC0000", 24'h0C0000, 1'b1, 1'b1);
  endtask

  task automatic t_index_data;
    logic [7:0] v;
    reg_put(8'h42, 8'hA5);
    reg_put(8'h43, 8'h3C);
    reg_get(8'h42, v);
    check("R2 stored at 0x42", 32'(v), 32'hA5);
    io_get(1'b0, v);
    check("R3 index readback", 32'(v), 32'h42);
    reg_get(8'h43, v);
    check("R2 stored at 0x43", 32'(v), 32'h3C);
    io_addr0 = 1'b1; io_rd = 1'b0;
    #1 check("R3 idle rdata zero", 32'(io_rdata), 32'h00);
  endtask

  task automatic t_modes;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        logic [23:0] base;
        logic er, ew;
        base = 24'h0C0000 + 24'(c) * 24'h8000;
        er = m[0];
        ew = m[1];
        reg_put(8'h13, 8'(1 << c));
        reg_put(8'h14, 8'(m));
        route_chk($sformatf("R5 mode%0d seg%0d base", m, c), base, er, ew);
        route_chk($sformatf("R4 mode%0d seg%0d +7FFF", m, c), base + 24'h7FFF, er, ew);
        route_chk($sformatf("R4 mode%0d seg%0d +8000", m, c), base + 24'h8000, 1'b0, 1'b0);
        if (c > 0)
          route_chk($sformatf("R4 mode%0d seg%0d -1", m, c), base - 24'h1, 1'b0, 1'b0);
      end
    end
  endtask

  task automatic t_bios;
    reg_put(8'h14, 8'h01);
    check("R7 bios rd for 0x01", 32'(bios_shadow_rd), 32'd1);
    check("R7 bios wr for 0x01", 32'(bios_shadow_wr), 32'd0);
    reg_put(8'h14, 8'h02);
    check("R7 bios rd for 0x02", 32'(bios_shadow_rd), 32'd0);
    check("R7 bios wr for 0x02", 32'(bios_shadow_wr), 32'd1);
  endtask

  task automatic t_window;
    reg_put(8'h13, 8'hFF);
    reg_put(8'h14, 8'h03);
    route_chk("R6 below window", 24'h0BFFFF, 1'b0, 1'b0);
    route_chk("R6 window start", 24'h0C0000, 1'b1, 1'b1);
    route_chk("R6 window end", 24'h0FFFFF, 1'b1, 1'b1);
    route_chk("R6 above window", 24'h100000, 1'b0, 1'b0);
    route_chk("R6 low memory", 24'h000400, 1'b0, 1'b0);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    reg_put(8'h1F, 8'h78);
    reg_put(8'h20, 8'h12);
    reg_put(8'hC0, 8'h34);
    reg_put(8'hFF, 8'h56);
    cpu_alt = 1'b1;
    reg_get(8'h1F, v); check("R8 alt 0x1F unmasked", 32'(v), 32'h78);
    reg_get(8'h20, v); check("R8 alt 0x20 masked", 32'(v), 32'hFF);
    reg_get(8'hBF, v); check("R8 alt 0xBF unmasked", 32'(v), 32'hFF);
    reg_get(8'hC0, v); check("R8 alt 0xC0 masked", 32'(v), 32'hFF);
    io_get(1'b0, v);   check("R8 alt index port unmasked", 32'(v), 32'hC0);
    reg_get(8'hFF, v); check("R8 alt 0xFF masked", 32'(v), 32'hFF);
    cpu_alt = 1'b0;
    reg_get(8'h20, v); check("R8 plain 0x20 kept", 32'(v), 32'h12);
    reg_get(8'hC0, v); check("R8 plain 0xC0 kept", 32'(v), 32'h34);
    reg_get(8'hFF, v); check("R8 plain 0xFF kept", 32'(v), 32'h56);
    reg_get(8'h1F, v); check("R8 plain 0x1F kept", 32'(v), 32'h78);
  endtask

  initial begin
    rst_n = 1'b0;
    io_addr0 = 1'b0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    mem_addr = '0; mem_wr = 1'b0; cpu_alt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index_data();
    t_modes();
    t_bios();
    t_window();
    t_mask();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule